// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns an addressing-mode code, two register values (base and index) and an immediate offset into the memory address of a load operand. Most modes are pure arithmetic and their result appears one clock after the request. One mode treats the base register as a pointer to a pointer. For that mode the block fetches a word from a synchronous memory port and returns that word as the address. Two auto-modify modes also produce a new base register value for the register file to write back.

Upstream logic presents a request with `req_valid_i` whenever `busy_o` is low. It then waits for either `addr_valid_o` or `illegal_mode_o`. While a pointer fetch is outstanding the block reports busy and does not accept requests. Instruction decode, the load of the data itself and address translation are handled by other blocks.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `addr_valid_o`, `wb_valid_o`, `illegal_mode_o`, `mem_req_valid_o` and `busy_o` are all 0.
- R2: Mode code 0 (absolute): one cycle after an accepted request, `addr_valid_o` is 1 and `addr_out_o` equals the offset.
- R3: Mode code 1 (register indirect): one cycle after acceptance the address equals the base value.
- R4: Mode code 2 (displaced): one cycle after acceptance the address equals base plus offset, modulo 2^AW.
- R5: Mode code 3 (indexed): one cycle after acceptance the address equals base plus index, modulo 2^AW.
- R6: Mode code 4 (scaled): one cycle after acceptance the address equals base plus four times index, modulo 2^AW.
- R7: Mode code 5 (memory indirect): one cycle after acceptance, `mem_req_valid_o` pulses for exactly one cycle with `mem_req_addr_o` equal to the base value, and `busy_o` rises. A response is taken only in a cycle after that pulse. In the cycle after `mem_rsp_valid_i` is taken, `addr_valid_o` is 1, `addr_out_o` equals the response word and `busy_o` is 0.
- R8: Mode code 6 (auto-increment, post-modify): the address equals the base value, and in the same cycle `wb_valid_o` is 1 with `wb_data_o` equal to base plus 4.
- R9: Mode code 7 (auto-decrement, pre-modify): the address equals base minus 4, and in the same cycle `wb_valid_o` is 1 with `wb_data_o` equal to base minus 4.
- R10: Mode codes 8 to 15 are illegal. One cycle after acceptance `illegal_mode_o` pulses, while `addr_valid_o`, `wb_valid_o` and `mem_req_valid_o` stay 0.
- R11: While `busy_o` is 1, new requests are ignored. No address and no second memory request result from them. A response that arrives while no fetch is outstanding produces no address.
- R12: `wb_valid_o` is asserted only for mode codes 6 and 7. `mem_req_valid_o` is asserted only for mode code 5.
- R13: Each accepted legal request yields exactly one single-cycle `addr_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Address request, taken when `busy_o` is low |
| req_mode_i | input | 4 | Addressing-mode code |
| base_i | input | AW | Base register value |
| index_i | input | AW | Index register value |
| offset_i | input | AW | Immediate offset or absolute address |
| busy_o | output | 1 | A pointer fetch is outstanding |
| mem_req_valid_o | output | 1 | Pointer fetch request pulse |
| mem_req_addr_o | output | AW | Pointer fetch address |
| mem_rsp_valid_i | input | 1 | Pointer fetch response strobe |
| mem_rsp_data_i | input | AW | Pointer word returned by memory |
| addr_valid_o | output | 1 | Final address strobe |
| addr_out_o | output | AW | Final effective address |
| wb_valid_o | output | 1 | Base register writeback strobe |
| wb_data_o | output | AW | New base register value |
| illegal_mode_o | output | 1 | Illegal mode code seen |

## Verification
The bench sweeps every mode code across base, index and offset values chosen so that sums wrap past the top of an 8-bit address. A design that drops the carry-out or scales the wrong operand shows a wrong address there. The two auto-modify modes are checked against each other: confusing pre-decrement with post-decrement shifts the address by four while the writeback stays correct. Pointer fetches are run with different response delays while a new request is held on the input. A design that accepts work while busy would issue a second fetch or an early address. A design that emits the fetched pointer twice would fail the pulse check. Stray responses and the illegal codes 8 to 15 must leave every strobe low.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        AM_ABS     = 4'd0,
        AM_REG     = 4'd1,
        AM_DISP    = 4'd2,
        AM_IDX     = 4'd3,
        AM_SCALED  = 4'd4,
        AM_MEMIND  = 4'd5,
        AM_AUTOINC = 4'd6,
        AM_AUTODEC = 4'd7
    } eag_mode_e;

    typedef enum logic [1:0] {
        KIND_DIRECT,
        KIND_INDIRECT,
        KIND_ILLEGAL
    } eag_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT
    } eag_seq_e;

    function automatic eag_kind_e classify_mode(input logic [3:0] code);
        if (code[3])
            return KIND_ILLEGAL;
        else if (code == AM_MEMIND)
            return KIND_INDIRECT;
        else
            return KIND_DIRECT;
    endfunction

endpackage

// File: rtl/eag_mode_alu.sv
module eag_mode_alu
    import eag_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SCALE_LOG2 = 2,
    parameter int STEP       = 4
) (
    input  logic [3:0]    mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [AW-1:0] offset_i,
    output eag_kind_e     kind_o,
    output logic [AW-1:0] addr_o,
    output logic          wb_en_o,
    output logic [AW-1:0] wb_data_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] scaled_idx;
    logic [AW-1:0] base_dec;

    assign scaled_idx = index_i << SCALE_LOG2;
    assign base_dec   = base_i - STEP_V;
    assign kind_o     = classify_mode(mode_i);

    always_comb begin
        addr_o    = base_i;
        wb_en_o   = 1'b0;
        wb_data_o = base_i;
        case (mode_i)
            AM_ABS:     addr_o = offset_i;
            AM_REG:     addr_o = base_i;
            AM_DISP:    addr_o = base_i + offset_i;
            AM_IDX:     addr_o = base_i + index_i;
            AM_SCALED:  addr_o = base_i + scaled_idx;
            AM_AUTOINC: begin
                addr_o    = base_i;
                wb_en_o   = 1'b1;
                wb_data_o = base_i + STEP_V;
            end
            AM_AUTODEC: begin
                addr_o    = base_dec;
                wb_en_o   = 1'b1;
                wb_data_o = base_dec;
            end
            default:    addr_o = base_i;
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
    import eag_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] ptr_addr_i,
    input  logic          rsp_valid_i,
    output logic          busy_o,
    output logic          mem_req_valid_o,
    output logic [AW-1:0] mem_req_addr_o,
    output logic          done_o
);
    eag_seq_e      state_q;
    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            ptr_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (start_i) begin
                    state_q <= SQ_ISSUE;
                    ptr_q   <= ptr_addr_i;
                end
                SQ_ISSUE: state_q <= SQ_WAIT;
                SQ_WAIT:  if (rsp_valid_i) state_q <= SQ_IDLE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy_o          = (state_q != SQ_IDLE);
    assign mem_req_valid_o = (state_q == SQ_ISSUE);
    assign mem_req_addr_o  = ptr_q;
    assign done_o          = (state_q == SQ_WAIT) && rsp_valid_i;

    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |=> !mem_req_valid_o); // R7
    AST_FETCH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |-> $past(start_i)); // R7
    AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !done_o); // R11
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SCALE_LOG2 = 2,
    parameter int STEP       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid_i,
    input  logic [3:0]    req_mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [AW-1:0] offset_i,
    output logic          busy_o,
    output logic          mem_req_valid_o,
    output logic [AW-1:0] mem_req_addr_o,
    input  logic          mem_rsp_valid_i,
    input  logic [AW-1:0] mem_rsp_data_i,
    output logic          addr_valid_o,
    output logic [AW-1:0] addr_out_o,
    output logic          wb_valid_o,
    output logic [AW-1:0] wb_data_o,
    output logic          illegal_mode_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    eag_kind_e     kind;
    logic [AW-1:0] alu_addr;
    logic          alu_wb_en;
    logic [AW-1:0] alu_wb_data;
    logic          accept;
    logic          fetch_done;

    eag_mode_alu #(.AW(AW), .SCALE_LOG2(SCALE_LOG2), .STEP(STEP)) alu_i (
        .mode_i    (req_mode_i),
        .base_i    (base_i),
        .index_i   (index_i),
        .offset_i  (offset_i),
        .kind_o    (kind),
        .addr_o    (alu_addr),
        .wb_en_o   (alu_wb_en),
        .wb_data_o (alu_wb_data)
    );

    assign accept = req_valid_i && !busy_o;

    eag_seq #(.AW(AW)) seq_i (
        .clk             (clk),
        .rst             (rst),
        .start_i         (accept && (kind == KIND_INDIRECT)),
        .ptr_addr_i      (base_i),
        .rsp_valid_i     (mem_rsp_valid_i),
        .busy_o          (busy_o),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_addr_o  (mem_req_addr_o),
        .done_o          (fetch_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_valid_o   <= 1'b0;
            addr_out_o     <= '0;
            wb_valid_o     <= 1'b0;
            wb_data_o      <= '0;
            illegal_mode_o <= 1'b0;
        end else begin
            addr_valid_o   <= fetch_done || (accept && (kind == KIND_DIRECT));
            wb_valid_o     <= accept && (kind == KIND_DIRECT) && alu_wb_en;
            illegal_mode_o <= accept && (kind == KIND_ILLEGAL);
            if (fetch_done)
                addr_out_o <= mem_rsp_data_i;
            else if (accept && (kind == KIND_DIRECT))
                addr_out_o <= alu_addr;
            if (accept && alu_wb_en)
                wb_data_o <= alu_wb_data;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!addr_valid_o && !wb_valid_o && !illegal_mode_o
                 && !mem_req_valid_o && !busy_o)); // R1
    AST_WB_WITH_ADDR: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> addr_valid_o); // R8
    AST_WB_STEP: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> ((wb_data_o == addr_out_o) || (wb_data_o == addr_out_o + STEP_V))); // R9
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
        illegal_mode_o |-> (!addr_valid_o && !wb_valid_o && !mem_req_valid_o)); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !mem_rsp_valid_i) |=> !addr_valid_o); // R11
endmodule

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb_top;
    localparam int AW = 8;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic [3:0]    req_mode;
    logic [AW-1:0] base_v, index_v, offset_v;
    logic          busy, mem_req_valid, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr, mem_rsp_data;
    logic          addr_valid, wb_valid, illegal_mode;
    logic [AW-1:0] addr_out, wb_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    eff_addr_gen #(.AW(AW), .SCALE_LOG2(2), .STEP(4)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_mode_i(req_mode),
        .base_i(base_v), .index_i(index_v), .offset_i(offset_v),
        .busy_o(busy), .mem_req_valid_o(mem_req_valid), .mem_req_addr_o(mem_req_addr),
        .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_data_i(mem_rsp_data),
        .addr_valid_o(addr_valid), .addr_out_o(addr_out),
        .wb_valid_o(wb_valid), .wb_data_o(wb_data),
        .illegal_mode_o(illegal_mode)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            6: return "R8";
            7: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int exp_addr(input int m, input int b, input int i, input int o);
        case (m)
            0: return o;
            1: return b;
            2: return (b + o) & MASK;
            3: return (b + i) & MASK;
            4: return (b + i * 4) & MASK;
            6: return b;
            7: return (b - 4) & MASK;
            default: return 0;
        endcase
    endfunction

    task automatic run_direct(input int m, input int b, input int i, input int o);
        string t;
        bit legal;
        bit autom;
        t     = mode_tag(m);
        legal = (m < 8);
        autom = (m == 6) || (m == 7);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 4'(m);
        base_v = AW'(b); index_v = AW'(i); offset_v = AW'(o);
        @(negedge clk);
        req_valid = 1'b0;
        check(t, "addr_valid", int'(addr_valid), int'(legal));
        if (legal) check(t, "addr_out", int'(addr_out), exp_addr(m, b, i, o));
        check(t, "illegal_mode", int'(illegal_mode), int'(!legal));
        check("R12", "wb_valid", int'(wb_valid), int'(autom));
        if (m == 6) check("R8", "wb_data", int'(wb_data), (b + 4) & MASK);
        if (m == 7) check("R9", "wb_data", int'(wb_data), (b - 4) & MASK);
        check("R12", "mem_req_valid", int'(mem_req_valid), 0);
        @(negedge clk);
        check("R13", "addr_valid pulse end", int'(addr_valid), 0);
    endtask

    task automatic run_indirect(input int b, input int ptr, input int delay);
        @(negedge clk);
        req_valid = 1'b1; req_mode = 4'd5; base_v = AW'(b);
        @(negedge clk);
        req_mode = 4'd1; base_v = AW'((b + 9) & MASK);
        check("R7", "mem_req_valid", int'(mem_req_valid), 1);
        check("R7", "mem_req_addr", int'(mem_req_addr), b);
        check("R7", "busy", int'(busy), 1);
        check("R7", "addr_valid early", int'(addr_valid), 0);
        @(negedge clk);
        check("R7", "mem_req single", int'(mem_req_valid), 0);
        check("R11", "addr_valid while busy", int'(addr_valid), 0);
        for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            check("R11", "busy held", int'(busy), 1);
            check("R11", "no second fetch", int'(mem_req_valid), 0);
            check("R11", "no address while busy", int'(addr_valid), 0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = AW'(ptr); req_valid = 1'b0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R7", "addr_valid after rsp", int'(addr_valid), 1);
        check("R7", "addr_out pointer", int'(addr_out), ptr);
        check("R7", "busy cleared", int'(busy), 0);
        check("R12", "no wb for indirect", int'(wb_valid), 0);
        @(negedge clk);
        check("R13", "indirect pulse once", int'(addr_valid), 0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b1; req_mode = 4'd1;
        base_v = 8'h55; index_v = '0; offset_v = '0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        check("R1", "addr_valid in reset", int'(addr_valid), 0);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "wb_valid in reset", int'(wb_valid), 0);
        check("R1", "illegal in reset", int'(illegal_mode), 0);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1", "addr_valid after reset", int'(addr_valid), 0);
        check("R1", "mem_req after reset", int'(mem_req_valid), 0);

        for (int m = 0; m < 16; m++) begin
            if (m == 5) continue;
            for (int b = 0; b < 256; b += 37)
                for (int i = 3; i < 256; i += 53)
                    for (int o = 1; o < 256; o += 91)
                        run_direct(m, b, i, o);
        end
        run_direct(2, 8'hFF, 0, 8'h01);
        run_direct(4, 8'hF0, 8'h40, 0);
        run_direct(6, 8'hFC, 0, 0);
        run_direct(7, 8'h02, 0, 0);

        for (int d = 0; d < 5; d++)
            run_indirect((d * 61 + 7) & MASK, (d * 97 + 200) & MASK, d);

        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = 8'hAA;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check("R11", "stray response ignored", int'(addr_valid), 0);
        check("R11", "stray response no busy", int'(busy), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule